// File: doc/BRIEF.md
# Pipelined Crossbar Switch Allocator

This block decides which requesters may use an on-chip crossbar in each cycle, and then moves the winning payloads across it. By default it has eight requester-side inputs and nine destination outputs. Eight of the outputs lead to cache banks and one leads to the I/O port. Each input presents a payload together with the index of the output it wants. The block captures the request into a per-input holding register. It then arbitrates every output column with its own round-robin pointer, announces the winners together with one-hot crosspoint selects, and in the final stage delivers each winner's payload on its output.

All four stages are pipelined. A fresh set of requests can be accepted on every clock while earlier sets are still in arbitration, notification or transfer. An input that loses keeps its payload parked in the holding register and competes again on the next cycle, with no action from the requester. A request that meets no contention always takes the same number of cycles, whatever its input and output.

Top module: `xbar_alloc`

## Requirements
- R1: While reset is asserted (synchronous, active low) and on the first cycle after it, `out_valid`, `out_data`, `xp_sel` and `grant_notify` are all zero and every `req_ready` bit is 1.
- R2: A request is accepted when `req_valid[i]` and `req_ready[i]` are both high at a rising edge. If the request meets no contention, `out_valid[d]` is high after the fourth rising edge, counting the accepting edge as the first. The latency is the same for every input/output pair, and `out_valid` stays low before that edge.
- R3: Each `xp_sel` column `[o*N_IN +: N_IN]` has at most one bit set, and each input is selected by at most one column. An output with no grant drives `out_valid[o]` = 0 and its `out_data` slice as zero.
- R4: For a winning input `i` bound for output `o`, `grant_notify[i]` and `xp_sel[o*N_IN + i]` are high one edge before the payload appears on output `o`.
- R5: Each output keeps a round-robin pointer that resets to 0. Among the inputs that contend for an output, the first one found at or after the pointer, scanning upward and wrapping, wins. After the grant the pointer moves to the winner's index plus one, modulo N_IN.
- R6: While a held request is losing, `req_ready[i]` is low, and the held payload and destination do not change even when the input pins change. The request is later granted without being presented again.
- R7: In the cycle in which a held request wins, `req_ready[i]` is high. A new request can therefore be accepted on every edge, and back-to-back payloads from one input emerge on consecutive cycles.
- R8: Requests to distinct outputs are granted in the same cycle and emerge together.
- R9: A request whose destination index is N_OUT or larger is consumed (`req_ready` stays 1) and never produces a grant or any output activity.
- R10: Input `i` drives its payload on `req_data[i*DW +: DW]` and its destination on `req_dest[i*OW +: OW]`, where OW = clog2(N_OUT) (4 by default). Output `o` delivers the payload on `out_data[o*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_IN | Per-input request present |
| req_dest | input | N_IN*OW | Per-input destination output index |
| req_data | input | N_IN*DW | Per-input payload |
| req_ready | output | N_IN | Holding register can take a request this cycle |
| xp_sel | output | N_OUT*N_IN | Crosspoint selects, one column of N_IN bits per output |
| grant_notify | output | N_IN | Input has won and its crosspoint is set |
| out_valid | output | N_OUT | Output carries a payload this cycle |
| out_data | output | N_OUT*DW | Per-output payload, zero when idle |

## Verification
Lone requests over a spread of input/output pairs, including the I/O output, establish the fixed latency, the placement of the crosspoint select bit and the slicing of the payload. Three contention patterns distinguish a rotating arbiter from a fixed-priority one. These are a single prior grant followed by two contenders that straddle the pointer, all inputs converging on one bank so that the pointer wraps, and parked payloads whose input pins are overwritten while they wait. All inputs aimed at distinct outputs expose any needless serialisation. A single input streaming on consecutive cycles exposes a lost issue slot, and out-of-range destinations show whether invalid requests are dropped or wedge the input.

// File: rtl/xbar_alloc_pkg.sv
// Package: shared defaults and index helpers for the crossbar allocator.
// Assumes all index arguments are non-negative and below their limit.
package xbar_alloc_pkg;

    localparam int XB_IN_DEF  = 8;
    localparam int XB_OUT_DEF = 9;
    localparam int XB_DW_DEF  = 32;

    // Width of an index able to address n items (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Sum of two in-range indices, wrapped into [0, lim).
    function automatic int wrap_add(input int a, input int b, input int lim);
        int s;
        s = a + b;
        if (s >= lim) s = s - lim;
        return s;
    endfunction

endpackage

// File: rtl/xbar_req_hold.sv
// Request capture stage: one holding register per input.
// A slot accepts new data when it is empty or when its current request is
// being granted this cycle. Destinations outside the output range are
// consumed without being stored. Assumes `win` depends only on the held state.
module xbar_req_hold #(
    parameter int N_IN  = xbar_alloc_pkg::XB_IN_DEF,
    parameter int N_OUT = xbar_alloc_pkg::XB_OUT_DEF,
    parameter int DW    = xbar_alloc_pkg::XB_DW_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_IN-1:0]             req_valid,
    input  logic [N_IN*xbar_alloc_pkg::idx_w(N_OUT)-1:0] req_dest,
    input  logic [N_IN*DW-1:0]          req_data,
    input  logic [N_IN-1:0]             win,
    output logic [N_IN-1:0]             req_ready,
    output logic [N_IN-1:0]             hold_v,
    output logic [N_IN*xbar_alloc_pkg::idx_w(N_OUT)-1:0] hold_dest,
    output logic [N_IN*DW-1:0]          hold_data
);
    localparam int OW = xbar_alloc_pkg::idx_w(N_OUT);

    logic [N_IN-1:0] in_range;

    // Slot is free when empty or leaving this cycle; flag legal destinations.
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            req_ready[i] = !hold_v[i] || win[i];
            in_range[i]  = {{(32-OW){1'b0}}, req_dest[i*OW +: OW]} < 32'(N_OUT);
        end
    end

    // Valid flags: load on free slots, reset to empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= '0;
        end else begin
            for (int i = 0; i < N_IN; i++)
                if (req_ready[i]) hold_v[i] <= req_valid[i] && in_range[i];
        end
    end

    // Payload and destination: load on free slots only.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_IN; i++) begin
            if (req_ready[i]) begin
                hold_dest[i*OW +: OW] <= req_dest[i*OW +: OW];
                hold_data[i*DW +: DW] <= req_data[i*DW +: DW];
            end
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_chk
        // R6: a losing request stays parked and unchanged.
        a_r6_park_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_v[i] && !win[i]) |=> (hold_v[i] && $stable(hold_data[i*DW +: DW])
                                        && $stable(hold_dest[i*OW +: OW])));
        // R9: nothing out of range is ever held.
        a_r9_held_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            hold_v[i] |-> ({{(32-OW){1'b0}}, hold_dest[i*OW +: OW]} < 32'(N_OUT)));
    end

endmodule

// File: rtl/xbar_rr_arb.sv
// Round-robin arbiter for one output column.
// Grants at most one requester per cycle: the first one found at or after the
// pointer. The pointer then moves to one past the winner. Combinational grant,
// registered pointer.
module xbar_rr_arb #(
    parameter int N = xbar_alloc_pkg::XB_IN_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = xbar_alloc_pkg::idx_w(N);

    logic [PW-1:0] ptr_q;
    logic          hit;
    int            win_idx;
    int            scan_idx;

    // Scan from the pointer upward with wrap, pick the first requester.
    always_comb begin
        hit      = 1'b0;
        win_idx  = 0;
        scan_idx = 0;
        for (int k = 0; k < N; k++) begin
            scan_idx = xbar_alloc_pkg::wrap_add(int'(ptr_q), k, N);
            if (!hit && req[scan_idx]) begin
                hit     = 1'b1;
                win_idx = scan_idx;
            end
        end
        gnt = '0;
        if (hit) gnt[win_idx] = 1'b1;
    end

    // Pointer: advance past the winner after every grant.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q <= '0;
        else if (hit) ptr_q <= PW'(xbar_alloc_pkg::wrap_add(win_idx, 1, N));
    end

    // R3: never more than one grant per column.
    a_r3_arb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R3: grants only go to requesters.
    a_r3_arb_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    // R5: the same input wins twice running only when it is alone.
    a_r5_rr_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && (gnt == $past(gnt))) |-> ($countones(req) == 1));

endmodule

// File: rtl/xbar_xfer.sv
// Notification and transfer stages.
// Registers the grant matrix with its payloads, then sets the crosspoint
// selects and grant notifications. In the next stage each output column
// ORs the selected payloads into a registered output. Assumes each column of
// gnt_mat is one-hot or zero.
module xbar_xfer #(
    parameter int N_IN  = xbar_alloc_pkg::XB_IN_DEF,
    parameter int N_OUT = xbar_alloc_pkg::XB_OUT_DEF,
    parameter int DW    = xbar_alloc_pkg::XB_DW_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_OUT*N_IN-1:0]   gnt_mat,
    input  logic [N_IN*DW-1:0]      hold_data,
    output logic [N_OUT*N_IN-1:0]   xp_sel,
    output logic [N_IN-1:0]         grant_notify,
    output logic [N_OUT-1:0]        out_valid,
    output logic [N_OUT*DW-1:0]     out_data
);
    logic [N_OUT*N_IN-1:0] g2_q;
    logic [N_IN*DW-1:0]    d2_q;
    logic [N_IN*DW-1:0]    d3_q;
    logic [N_OUT-1:0]      ov_d;
    logic [N_OUT*DW-1:0]   od_d;
    logic [N_OUT-1:0]      row_sel [N_IN];

    // Decision stage: register grants (reset) alongside held payloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g2_q   <= '0;
            xp_sel <= '0;
        end else begin
            g2_q   <= gnt_mat;
            xp_sel <= g2_q;
        end
    end

    // Payload pipeline following the grants; needs no reset.
    always_ff @(posedge clk) begin
        d2_q <= hold_data;
        d3_q <= d2_q;
    end

    // Winner notification: an input is told when any column selects it.
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            for (int o = 0; o < N_OUT; o++) row_sel[i][o] = xp_sel[o*N_IN + i];
            grant_notify[i] = |row_sel[i];
        end
    end

    // Crosspoint mux: each column ORs the payloads it selects.
    always_comb begin
        ov_d = '0;
        od_d = '0;
        for (int o = 0; o < N_OUT; o++) begin
            for (int i = 0; i < N_IN; i++) begin
                if (xp_sel[o*N_IN + i]) begin
                    ov_d[o]              = 1'b1;
                    od_d[o*DW +: DW]     = od_d[o*DW +: DW] | d3_q[i*DW +: DW];
                end
            end
        end
    end

    // Transfer stage: register the crossbar outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= ov_d;
            out_data  <= od_d;
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_col_chk
        // R3: one-hot crosspoint column.
        a_r3_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(xp_sel[o*N_IN +: N_IN]));
        // R3: an idle output drives zero data.
        a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[o] |-> (out_data[o*DW +: DW] == '0));
        // R2: a grant reaches the output a fixed three edges later.
        a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_mat[o*N_IN +: N_IN] != '0) |=> ##2 out_valid[o]);
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_row_chk
        // R3: an input is connected to at most one output.
        a_r3_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(row_sel[i]));
        // R4: notification is followed by data on the next edge.
        a_r4_notify_then_data: assert property (@(posedge clk) disable iff (!rst_n)
            grant_notify[i] |=> (out_valid != '0));
    end

endmodule

// File: rtl/xbar_alloc.sv
// Top level of the pipelined crossbar allocator.
// Stages: capture into holding registers, per-output round-robin arbitration
// registered as a grant matrix, crosspoint selects with notification, and
// a registered transfer. Every input requests a single output at a time.
module xbar_alloc #(
    parameter int N_IN  = xbar_alloc_pkg::XB_IN_DEF,
    parameter int N_OUT = xbar_alloc_pkg::XB_OUT_DEF,
    parameter int DW    = xbar_alloc_pkg::XB_DW_DEF
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [N_IN-1:0]                               req_valid,
    input  logic [N_IN*xbar_alloc_pkg::idx_w(N_OUT)-1:0]  req_dest,
    input  logic [N_IN*DW-1:0]                            req_data,
    output logic [N_IN-1:0]                               req_ready,
    output logic [N_OUT*N_IN-1:0]                         xp_sel,
    output logic [N_IN-1:0]                               grant_notify,
    output logic [N_OUT-1:0]                              out_valid,
    output logic [N_OUT*DW-1:0]                           out_data
);
    localparam int OW = xbar_alloc_pkg::idx_w(N_OUT);

    logic [N_IN-1:0]       hold_v;
    logic [N_IN*OW-1:0]    hold_dest;
    logic [N_IN*DW-1:0]    hold_data;
    logic [N_IN-1:0]       win;
    logic [N_OUT*N_IN-1:0] gnt_mat;
    logic [N_OUT*N_IN-1:0] col_req;

    xbar_req_hold #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_dest  (req_dest),
        .req_data  (req_data),
        .win       (win),
        .req_ready (req_ready),
        .hold_v    (hold_v),
        .hold_dest (hold_dest),
        .hold_data (hold_data)
    );

    // Request matrix: column o holds the inputs parked for output o.
    always_comb begin
        for (int o = 0; o < N_OUT; o++)
            for (int i = 0; i < N_IN; i++)
                col_req[o*N_IN + i] = hold_v[i] && (hold_dest[i*OW +: OW] == OW'(o));
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_arb
        xbar_rr_arb #(.N(N_IN)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (col_req[o*N_IN +: N_IN]),
            .gnt   (gnt_mat[o*N_IN +: N_IN])
        );
    end

    // Row reduction: an input wins when any column grants it.
    always_comb begin
        win = '0;
        for (int o = 0; o < N_OUT; o++) win = win | gnt_mat[o*N_IN +: N_IN];
    end

    xbar_xfer #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW)) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .gnt_mat      (gnt_mat),
        .hold_data    (hold_data),
        .xp_sel       (xp_sel),
        .grant_notify (grant_notify),
        .out_valid    (out_valid),
        .out_data     (out_data)
    );

endmodule

// File: tb/xbar_alloc_tb.sv
`timescale 1ns/1ps
// Bench for xbar_alloc with default sizes (8 inputs, 9 outputs, 32-bit data).
module xbar_alloc_tb;
    localparam int NI = 8;
    localparam int NO = 9;
    localparam int DW = 32;
    localparam int OW = 4;

    typedef struct packed {
        logic [2:0]  src;
        logic [3:0]  dst;
        logic [31:0] dat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 4'd0, 32'h1111_0000},
        '{3'd7, 4'd8, 32'h2222_7008},
        '{3'd3, 4'd3, 32'h3333_3003},
        '{3'd6, 4'd2, 32'h4444_6002},
        '{3'd1, 4'd8, 32'h5555_1008},
        '{3'd4, 4'd5, 32'h6666_4005}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NI-1:0]      req_valid = '0;
    logic [NI*OW-1:0]   req_dest = '0;
    logic [NI*DW-1:0]   req_data = '0;
    logic [NI-1:0]      req_ready;
    logic [NO*NI-1:0]   xp_sel;
    logic [NI-1:0]      grant_notify;
    logic [NO-1:0]      out_valid;
    logic [NO*DW-1:0]   out_data;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    xbar_alloc u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_dest     (req_dest),
        .req_data     (req_data),
        .req_ready    (req_ready),
        .xp_sel       (xp_sel),
        .grant_notify (grant_notify),
        .out_valid    (out_valid),
        .out_data     (out_data)
    );

    task automatic check(input string tag, input logic [NO*DW-1:0] act,
                         input logic [NO*DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One uncontended request; checks R2, R3, R4, R10 at the exact edges.
    task automatic do_single(input int s, input int d, input logic [31:0] dat);
        logic [NO*DW-1:0] exp_od;
        @(negedge clk);
        req_valid[s]          = 1'b1;
        req_dest[s*OW +: OW]  = OW'(d);
        req_data[s*DW +: DW]  = dat;
        @(negedge clk);                         // after accepting edge
        req_valid = '0;
        req_data  = '1;
        @(negedge clk);                         // after edge 2
        check("R2 no early output", out_valid, '0);
        @(negedge clk);                         // after edge 3
        check("R4 notify", grant_notify, NI'(1) << s);
        check("R4 crosspoint", xp_sel, (NO*NI)'(1) << (d*NI + s));
        check("R2 still no output", out_valid, '0);
        @(negedge clk);                         // after edge 4
        exp_od = '0;
        exp_od[d*DW +: DW] = dat;
        check("R2 valid at fixed latency", out_valid, NO'(1) << d);
        check("R10 R3 data slice, idle zero", out_data, exp_od);
        @(negedge clk);
        check("R3 idle after transfer", out_valid, '0);
    endtask

    initial begin
        // R1: reset state, during and just after reset.
        repeat (3) @(negedge clk);
        check("R1 out_valid", out_valid, '0);
        check("R1 out_data", out_data, '0);
        check("R1 xp_sel", xp_sel, '0);
        check("R1 notify", grant_notify, '0);
        check("R1 ready", req_ready, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after release", req_ready, 8'hFF);
        check("R1 out_valid after release", out_valid, '0);

        // Vector table walk: lone requests over many pairs.
        for (int v = 0; v < NV; v++)
            do_single(int'(VECS[v].src), int'(VECS[v].dst), VECS[v].dat);

        // R5: rotation. After reset, grant 5 on output 3 moves the pointer to 6.
        do_reset();
        do_single(5, 3, 32'hAAAA_0005);
        @(negedge clk);
        req_valid = 8'b1000_0100;
        req_dest[2*OW +: OW] = 4'd3;
        req_dest[7*OW +: OW] = 4'd3;
        req_data[2*DW +: DW] = 32'hA2A2_A2A2;
        req_data[7*DW +: DW] = 32'hA7A7_A7A7;
        @(negedge clk);
        req_valid = '0;
        req_data  = '1;
        check("R6 loser not ready, winner ready", req_ready, 8'b1111_1011);
        @(negedge clk);
        @(negedge clk);
        check("R5 input 7 notified first", grant_notify, 8'b1000_0000);
        @(negedge clk);
        check("R5 first winner past pointer", out_data[3*DW +: DW], 32'hA7A7_A7A7);
        check("R4 loser notified next", grant_notify, 8'b0000_0100);
        @(negedge clk);
        check("R6 R5 wrapped winner delivered", out_data[3*DW +: DW], 32'hA2A2_A2A2);
        check("R5 valid on bank 3", out_valid, 9'b0_0000_1000);

        // R5/R6: every input to output 3; pointer is now 3.
        @(negedge clk);
        req_valid = '1;
        for (int i = 0; i < NI; i++) begin
            req_dest[i*OW +: OW] = 4'd3;
            req_data[i*DW +: DW] = 32'hB000_0000 + i;
        end
        @(negedge clk);
        req_valid = '0;
        req_data  = {NI{32'hDEAD_BEEF}};
        check("R6 all parked except pointer winner", req_ready, 8'b0000_1000);
        @(negedge clk);
        @(negedge clk);
        check("R6 R7 ready while draining", req_ready, 8'b0011_1000);
        for (int k = 0; k < NI; k++) begin
            @(negedge clk);
            check("R5 rotation order", out_data[3*DW +: DW],
                  32'hB000_0000 + ((3 + k) % NI));
            check("R3 single column active", out_valid, 9'b0_0000_1000);
        end
        @(negedge clk);
        check("R3 drained", out_valid, '0);

        // R8: all inputs to distinct outputs in one cycle.
        @(negedge clk);
        req_valid = '1;
        for (int i = 0; i < NI; i++) begin
            req_dest[i*OW +: OW] = OW'(i + 1);
            req_data[i*DW +: DW] = 32'hC000_0000 + i;
        end
        @(negedge clk);
        req_valid = '0;
        check("R8 all accepted", req_ready, 8'hFF);
        @(negedge clk);
        @(negedge clk);
        check("R8 all notified", grant_notify, 8'hFF);
        begin
            logic [NO*NI-1:0] exp_xp;
            exp_xp = '0;
            for (int i = 0; i < NI; i++) exp_xp[(i + 1)*NI + i] = 1'b1;
            check("R8 crosspoint diagonal", xp_sel, exp_xp);
        end
        @(negedge clk);
        check("R8 parallel valid", out_valid, 9'h1FE);
        for (int i = 0; i < NI; i++)
            check("R8 R10 parallel data", out_data[(i + 1)*DW +: DW], 32'hC000_0000 + i);

        // R7: one input streams three payloads to the I/O output.
        @(negedge clk);
        req_valid[4] = 1'b1;
        req_dest[4*OW +: OW] = 4'd8;
        req_data[4*DW +: DW] = 32'hD000_0000;
        @(negedge clk);
        check("R7 ready after first", req_ready[4], 1'b1);
        req_data[4*DW +: DW] = 32'hD000_0001;
        @(negedge clk);
        check("R7 ready after second", req_ready[4], 1'b1);
        req_data[4*DW +: DW] = 32'hD000_0002;
        @(negedge clk);
        req_valid = '0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7 back-to-back valid", out_valid, 9'h100);
            check("R7 back-to-back data", out_data[8*DW +: DW], 32'hD000_0000 + k);
        end
        @(negedge clk);
        check("R7 stream ended", out_valid, '0);

        // R9: out-of-range destinations are consumed silently.
        @(negedge clk);
        req_valid = 8'b0100_0010;
        req_dest[1*OW +: OW] = 4'd9;
        req_dest[6*OW +: OW] = 4'd15;
        @(negedge clk);
        req_valid = '0;
        check("R9 ready stays high", req_ready, 8'hFF);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R9 no output", out_valid, '0);
            check("R9 no notify", grant_notify, '0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule